// File: doc/BRIEF.md
# Converter Host Bus Control Decoder

This block sits between a parallel processor bus and a 12-bit conversion engine. It watches five host control pins: an active-high enable, an active-low select, a read/convert line, a byte-address line and a word/byte mode pin. From them it issues a one-cycle start pulse to the engine, together with a length select captured at that moment. It also drives the engine's result onto a 12-lane output bus, one enable per lane, which stands in for three-state drivers.

All five host pins are asynchronous to the system clock. Each passes through a two-flop synchroniser before any decision is made. The engine side (busy flag and result word) is in the clock domain and is used directly. A conversion is requested when enable is high, select is low and read/convert is low. Whichever of the three arrives last fires the start. While the engine reports busy, further requests are refused, but the length select is still recaptured on each new request. There is no back-pressure anywhere: the start pulse is a strobe the engine must take, and the output bus is a level-sensitive view of the result.

Top module: `adc_host_if`

## Requirements
- R1: After reset, `start_o` is 0, `len8_o` is 0, and `dout_o` and `doe_o` are all zero.
- R2: A start pulse is issued once when enable high, select low and read/convert low first hold together, whatever the order in which they arrive, including all at once. Holding the condition gives no further pulse.
- R3: No start pulse is issued while any one of the three start conditions is missing, whatever the other two do.
- R4: With each start pulse, `len8_o` shows the byte-address pin as sampled at that start (1 = 8-bit, 0 = 12-bit). It keeps that value when the pin changes afterwards without a new start transition.
- R5: While `busy_i` is high a start transition gives no pulse, but `len8_o` still takes the current byte-address value.
- R6: Lanes are enabled only when read/convert is high, `busy_i` is low, enable is high and select is low. Otherwise `doe_o` is 0, and `dout_o` is 0 on every disabled lane.
- R7: With the mode pin high (word mode), `doe_o` is 12'hFFF and `dout_o` equals `result_i`, whatever the byte-address pin is.
- R8: With the mode pin low and byte-address 0, `doe_o` is 12'hFF0 and `dout_o[11:4]` carries `result_i[11:4]`.
- R9: With the mode pin low and byte-address 1, `doe_o` is 12'h0FF, `dout_o[3:0]` carries `result_i[3:0]` and `dout_o[7:4]` is forced to 0. In byte mode, lanes 11:8 and 3:0 are never enabled together.
- R10: A start pulse appears on the third rising clock edge after the last start condition changes. Output lanes follow a change of a host pin after two rising edges, and follow `busy_i` and `result_i` in the same cycle.
- R11: A start pulse lasts exactly one clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_i | input | 1 | Host enable, active high, asynchronous |
| cs_n_i | input | 1 | Host select, active low, asynchronous |
| rc_i | input | 1 | Read (1) / convert (0), asynchronous |
| a0_i | input | 1 | Byte address / length select, asynchronous |
| mode12_i | input | 1 | 1 = whole-word read, 0 = byte reads |
| busy_i | input | 1 | Engine converting |
| result_i | input | 12 | Engine result word |
| start_o | output | 1 | One-cycle start strobe to the engine |
| len8_o | output | 1 | Length select captured at start (1 = 8-bit) |
| dout_o | output | 12 | Output lane data |
| doe_o | output | 12 | Output lane enables |

## Verification
The hardest case is a start transition that arrives while the engine is busy. The pulse must be refused, yet the length select must still change. The stimulus reaches this case by holding `busy_i` high, taking the start condition away and then bringing it back with the byte-address pin flipped. The test then watches `len8_o` move with no pulse on `start_o`. Each of the six arrival orders of the three start conditions is also driven one at a time, with the pulse count checked after every step.

// File: rtl/adc_hif_pkg.sv
package adc_hif_pkg;
  localparam int unsigned WORD_W   = 12;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned SYNC_N   = 2;
  localparam int unsigned CTRL_W   = 5;
  // control vector bit positions
  localparam int unsigned C_CE     = 0;
  localparam int unsigned C_CSN    = 1;
  localparam int unsigned C_RC     = 2;
  localparam int unsigned C_A0     = 3;
  localparam int unsigned C_M12    = 4;
  // idle levels: enable low, select high, read high, a0 low, word mode
  localparam logic [CTRL_W-1:0] CTRL_IDLE = 5'b10110;

  typedef enum logic [1:0] {RD_OFF, RD_WORD, RD_HI, RD_LO} rd_sel_e;
endpackage

// File: rtl/hif_sync.sv
module hif_sync #(
  parameter int unsigned W      = 5,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < int'(STAGES); s++) stg[s] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int s = 1; s < int'(STAGES); s++) stg[s] <= stg[s-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/hif_start_ctrl.sv
module hif_start_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_s,
  input  logic csn_s,
  input  logic rc_s,
  input  logic a0_s,
  input  logic busy_i,
  output logic start_o,
  output logic len8_o
);
  logic req, req_q, trig;
  logic start_q, len8_q;

  // request holds when all three conditions meet; its rise marks the last arrival
  assign req  = ce_s & ~csn_s & ~rc_s;
  assign trig = req & ~req_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      start_q <= 1'b0;
      len8_q  <= 1'b0;
    end else begin
      req_q   <= req;
      start_q <= trig & ~busy_i;
      if (trig) len8_q <= a0_s;  // recaptured even when refused
    end
  end

  assign start_o = start_q;
  assign len8_o  = len8_q;
endmodule

// File: rtl/hif_read_mux.sv
module hif_read_mux
  import adc_hif_pkg::*;
#(
  parameter int unsigned DW = WORD_W,
  parameter int unsigned BW = BYTE_W
) (
  input  logic          ce_s,
  input  logic          csn_s,
  input  logic          rc_s,
  input  logic          a0_s,
  input  logic          m12_s,
  input  logic          busy_i,
  input  logic [DW-1:0] result_i,
  output logic [DW-1:0] dout_o,
  output logic [DW-1:0] doe_o
);
  localparam int unsigned LOW_W = DW - BW;

  rd_sel_e sel;
  logic    rd_en;

  assign rd_en = rc_s & ~busy_i & ce_s & ~csn_s;

  always_comb begin
    if (!rd_en)     sel = RD_OFF;
    else if (m12_s) sel = RD_WORD;
    else if (!a0_s) sel = RD_HI;
    else            sel = RD_LO;
  end

  for (genvar i = 0; i < int'(DW); i++) begin : g_lane
    localparam bit IN_HI  = (i >= int'(LOW_W));
    localparam bit IN_LO  = (i < int'(BW));
    localparam bit LO_DAT = (i < int'(LOW_W));
    logic oe, d;
    always_comb begin
      oe = 1'b0;
      d  = 1'b0;
      unique case (sel)
        RD_WORD: begin oe = 1'b1;  d = result_i[i]; end
        RD_HI:   begin oe = IN_HI; d = IN_HI  ? result_i[i] : 1'b0; end
        RD_LO:   begin oe = IN_LO; d = LO_DAT ? result_i[i] : 1'b0; end
        default: begin oe = 1'b0;  d = 1'b0; end
      endcase
    end
    assign doe_o[i]  = oe;
    assign dout_o[i] = d;
  end
endmodule

// File: rtl/adc_host_if.sv
module adc_host_if
  import adc_hif_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_i,
  input  logic              cs_n_i,
  input  logic              rc_i,
  input  logic              a0_i,
  input  logic              mode12_i,
  input  logic              busy_i,
  input  logic [WORD_W-1:0] result_i,
  output logic              start_o,
  output logic              len8_o,
  output logic [WORD_W-1:0] dout_o,
  output logic [WORD_W-1:0] doe_o
);
  logic [CTRL_W-1:0] ctrl_raw, ctrl_s;

  always_comb begin
    ctrl_raw        = '0;
    ctrl_raw[C_CE]  = ce_i;
    ctrl_raw[C_CSN] = cs_n_i;
    ctrl_raw[C_RC]  = rc_i;
    ctrl_raw[C_A0]  = a0_i;
    ctrl_raw[C_M12] = mode12_i;
  end

  hif_sync #(.W(CTRL_W), .STAGES(SYNC_N), .RST_VAL(CTRL_IDLE)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  (ctrl_raw),
    .q_o  (ctrl_s)
  );

  hif_start_ctrl u_start (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_s   (ctrl_s[C_CE]),
    .csn_s  (ctrl_s[C_CSN]),
    .rc_s   (ctrl_s[C_RC]),
    .a0_s   (ctrl_s[C_A0]),
    .busy_i (busy_i),
    .start_o(start_o),
    .len8_o (len8_o)
  );

  hif_read_mux #(.DW(WORD_W), .BW(BYTE_W)) u_rd (
    .ce_s    (ctrl_s[C_CE]),
    .csn_s   (ctrl_s[C_CSN]),
    .rc_s    (ctrl_s[C_RC]),
    .a0_s    (ctrl_s[C_A0]),
    .m12_s   (ctrl_s[C_M12]),
    .busy_i  (busy_i),
    .result_i(result_i),
    .dout_o  (dout_o),
    .doe_o   (doe_o)
  );
endmodule

// File: rtl/adc_host_if_chk.sv
module adc_host_if_chk
  import adc_hif_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              busy_i,
  input logic              start_o,
  input logic [WORD_W-1:0] dout_o,
  input logic [WORD_W-1:0] doe_o
);
  // R5
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> $past(!busy_i));

  // R11
  start_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);

  // R6
  busy_float_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_i |-> (doe_o == '0));

  // R6
  idle_lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dout_o & ~doe_o) == '0);

  // R9
  lane_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (doe_o == 12'h000) || (doe_o == 12'hFFF) ||
    (doe_o == 12'hFF0) || (doe_o == 12'h0FF));
endmodule

bind adc_host_if adc_host_if_chk u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .busy_i (busy_i),
  .start_o(start_o),
  .dout_o (dout_o),
  .doe_o  (doe_o)
);

// File: tb/test_adc_host_if.sv
`timescale 1ns/1ps
module test_adc_host_if;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ce = 1'b0, csn = 1'b1, rc = 1'b1, a0 = 1'b0, m12 = 1'b1, busy = 1'b0;
  logic [11:0] res = '0;
  logic        start_o, len8_o;
  logic [11:0] dout_o, doe_o;

  int checks = 0;
  int fails  = 0;
  int pulses = 0;

  always #4 clk = ~clk;

  adc_host_if i_adc_host_if (
    .clk(clk), .rst_n(rst_n), .ce_i(ce), .cs_n_i(csn), .rc_i(rc),
    .a0_i(a0), .mode12_i(m12), .busy_i(busy), .result_i(res),
    .start_o(start_o), .len8_o(len8_o), .dout_o(dout_o), .doe_o(doe_o)
  );

  always @(posedge clk) begin
    #1;
    if (start_o) pulses++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic go_idle();
    ce = 1'b0; csn = 1'b1; rc = 1'b1;
    step(4);
  endtask

  task automatic apply(input int idx);
    case (idx)
      0: ce  = 1'b1;
      1: csn = 1'b0;
      default: rc = 1'b0;
    endcase
  endtask

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int base;
    step(3);
    rst_n = 1'b1;
    step(1);
    // R1 reset state
    chk(start_o == 1'b0, "R1 start", start_o, 0);
    chk(len8_o == 1'b0, "R1 len", len8_o, 0);
    chk(doe_o == 12'h000, "R1 doe", doe_o, 0);
    chk(dout_o == 12'h000, "R1 dout", dout_o, 0);

    // R2 / R3 / R4 / R10 / R11: every arrival order, both lengths
    for (int la = 0; la < 2; la++) begin
      for (int i = 0; i < 3; i++) begin
        for (int j = 0; j < 3; j++) begin
          for (int k = 0; k < 3; k++) begin
            if (i == j || j == k || i == k) continue;
            a0 = la[0];
            go_idle();
            base = pulses;
            apply(i); step(4);
            chk(pulses == base, "R3 one condition", pulses - base, 0);
            apply(j); step(4);
            chk(pulses == base, "R3 two conditions", pulses - base, 0);
            apply(k);
            step(2);
            chk(start_o == 1'b0, "R10 not early", start_o, 0);
            step(1);
            chk(start_o == 1'b1, "R10 third edge", start_o, 1);
            chk(len8_o == la[0], "R4 length", len8_o, la);
            step(1);
            chk(start_o == 1'b0, "R11 one cycle", start_o, 0);
            step(8);
            chk(pulses == base + 1, "R2 single pulse", pulses - base, 1);
            a0 = ~la[0]; step(4);
            chk(len8_o == la[0], "R4 held", len8_o, la);
          end
        end
      end
    end

    // R2 all three at once
    a0 = 1'b1;
    go_idle();
    base = pulses;
    ce = 1'b1; csn = 1'b0; rc = 1'b0;
    step(3);
    chk(start_o == 1'b1, "R2 simultaneous", start_o, 1);
    chk(len8_o == 1'b1, "R4 simultaneous len", len8_o, 1);
    step(6);
    chk(pulses == base + 1, "R2 simultaneous count", pulses - base, 1);

    // R3 enable low: toggle select and read/convert
    go_idle();
    base = pulses;
    for (int t = 0; t < 4; t++) begin
      csn = t[0]; rc = t[1]; step(4);
    end
    csn = 1'b0; rc = 1'b0; step(4);
    chk(pulses == base, "R3 enable low", pulses - base, 0);

    // R5 busy: refused, length recaptured
    a0 = 1'b0;
    go_idle();
    ce = 1'b1; csn = 1'b0; rc = 1'b0; step(6);
    chk(len8_o == 1'b0, "R5 prep len", len8_o, 0);
    busy = 1'b1;
    rc = 1'b1; step(4);
    base = pulses;
    a0 = 1'b1; rc = 1'b0; step(6);
    chk(pulses == base, "R5 refused", pulses - base, 0);
    chk(len8_o == 1'b1, "R5 relatch", len8_o, 1);
    busy = 1'b0; step(4);
    chk(pulses == base, "R5 no late pulse", pulses - base, 0);
    a0 = 1'b0; rc = 1'b1; step(4);
    rc = 1'b0; step(6);
    chk(pulses == base + 1, "R5 accepted after busy", pulses - base, 1);
    chk(len8_o == 1'b0, "R5 len after busy", len8_o, 0);

    // R6..R9 read sweep
    for (int v = 0; v < 5; v++) begin
      logic [11:0] r;
      case (v)
        0: r = 12'h000; 1: r = 12'hFFF; 2: r = 12'hA5C; 3: r = 12'h3C9; default: r = 12'h123;
      endcase
      for (int c = 0; c < 64; c++) begin
        logic en, em, ea;
        logic [11:0] eoe, ed;
        string tag;
        ce = c[0]; csn = c[1]; rc = c[2]; a0 = c[4]; m12 = c[5];
        busy = c[3]; res = r;
        step(2);
        en = c[2] & ~c[3] & c[0] & ~c[1];
        em = c[5]; ea = c[4];
        if (!en)      begin eoe = 12'h000; ed = 12'h000;     tag = "R6"; end
        else if (em)  begin eoe = 12'hFFF; ed = r;           tag = "R7"; end
        else if (!ea) begin eoe = 12'hFF0; ed = r & 12'hFF0; tag = "R8"; end
        else          begin eoe = 12'h0FF; ed = r & 12'h00F; tag = "R9"; end
        chk(doe_o == eoe, {tag, " enables"}, doe_o, eoe);
        chk(dout_o == ed, {tag, " data"}, dout_o, ed);
        if (!em) chk(!((|doe_o[11:8]) && (|doe_o[3:0])), "R9 exclusive", doe_o, eoe);
      end
    end

    // R10 same-cycle response to busy and result
    ce = 1'b1; csn = 1'b0; rc = 1'b1; m12 = 1'b1; busy = 1'b0; res = 12'h5A5;
    step(3);
    res = 12'h0F3; #1;
    chk(dout_o == 12'h0F3, "R10 result follows", dout_o, 12'h0F3);
    busy = 1'b1; #1;
    chk(doe_o == 12'h000, "R10 busy follows", doe_o, 0);
    busy = 1'b0;
    step(1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule